// File: doc/BRIEF.md
# LZW Code Stream Decompressor

This block turns a stream of 12-bit LZW codes back into the byte stream they were made from. No dictionary comes with the codes. The block rebuilds its own string table from the order in which codes arrive. Codes come in on a valid/ready port, and bytes leave on a second valid/ready port in their original order. A restart input brings the table back to its initial contents between frames.

Each dictionary entry stores a prefix code and one final byte. To expand a code, the controller follows the prefix links from the last byte back to the first, pushing each byte onto a LIFO stack. It then pops the stack onto the output, so the first byte of the string leaves first. The controller has four named states:

- `ST_IDLE` waits for a code. A valid code moves it to `ST_WALK`. A bad code only sets the error flag.
- `ST_WALK` pushes one byte per cycle. It moves to `ST_LINK` when it reaches a single-byte code.
- `ST_LINK` writes the new table entry and always moves to `ST_EMIT`.
- `ST_EMIT` returns to `ST_IDLE` when the last stacked byte is taken.

A restart forces `ST_IDLE` from any state.

Top module: `lzw_expander`

## Requirements
- R1: After reset, `code_ready` is 1, `out_valid` is 0 and `err_flag` is 0.
- R2: Codes 0 to 255 are defined from the start of every frame. Each one expands to the single byte whose value equals the code.
- R3: Every accepted code except the first of a frame adds one entry at the next free address. Addresses are assigned from 256 upward. The new entry is the previous code's string followed by the first byte of the current code's string. A defined code is output as its whole string, first byte first.
- R4: A code equal to the next free address (not yet defined) is output as the previous code's string followed by that string's first byte.
- R5: A code is rejected in two cases: it is greater than the next free address, or it equals the next free address while being the first code of a frame. A rejected code is consumed and produces no output bytes. It leaves the table and the previous code unchanged and sets `err_flag`, which stays at 1 until a restart.
- R6: Once address 4095 is filled, no further entries are added. Later codes in 0..4095 are still decoded.
- R7: A cycle with `frame_restart` at 1 does four things: it drops any string being expanded or output, returns the table to the single-byte entries only (next free address 256), clears `err_flag`, and refuses the code offered in that cycle.
- R8: A code is taken at a rising edge where both `code_valid` and `code_ready` are 1. `code_ready` then stays 0 until the edge where the string's last byte is taken. The first byte is valid w+1 cycles after acceptance. Here w is the string length for a defined code and one less for the not-yet-defined case. While `out_valid` is 1 and `out_ready` is 0, `out_data` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_restart | input | 1 | Synchronous start/flush of a frame |
| code_valid | input | 1 | Input code offered |
| code_ready | output | 1 | Block accepts a code this cycle |
| code_data | input | 12 | Input LZW code |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Sink takes the byte this cycle |
| out_data | output | 8 | Output byte |
| err_flag | output | 1 | Sticky flag for an undefined code |

## Verification
Acceptance of a code is seen on the same edge that takes it. After that edge, `code_ready` is 0 and, for a rejected code, `err_flag` is 1. The first byte of a string appears w+1 edges later: one edge for each stacked byte, plus one for the table update. Each following byte appears on the edge after the sink takes the previous one.

The bench keeps a behavioural model that steps once per rising edge and applies these exact delays. It compares `code_ready`, `out_valid`, `out_data` and `err_flag` at every falling edge, so a byte that arrives early, late or out of order shows up in the first cycle it differs.

// File: rtl/lzw_exp_pkg.sv
package lzw_exp_pkg;

    // Controller phases of the decompressor
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // waiting for a code
        ST_WALK = 2'd1,  // following prefix links, one byte pushed per cycle
        ST_LINK = 2'd2,  // adding the new entry and moving the history forward
        ST_EMIT = 2'd3   // popping stacked bytes to the output
    } lzw_state_e;

endpackage

// File: rtl/lzw_dict_mem.sv
module lzw_dict_mem #(
    parameter int CODE_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_prefix,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [CODE_W-1:0] rd_addr,
    output logic [CODE_W-1:0] rd_prefix,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              rd_literal
);

    localparam int DEPTH  = 1 << CODE_W;
    localparam int LIT    = 1 << BYTE_W;
    localparam int STORED = DEPTH - LIT;
    localparam int IDX_W  = $clog2(STORED);
    localparam int ENT_W  = CODE_W + BYTE_W;

    // Only the multi-byte entries are stored; single-byte codes are computed.
    logic [ENT_W-1:0]  mem [STORED];
    logic [CODE_W-1:0] rd_off;
    logic [CODE_W-1:0] wr_off;
    logic [ENT_W-1:0]  entry;

    assign rd_off = rd_addr - CODE_W'(LIT);
    assign wr_off = wr_addr - CODE_W'(LIT);

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_off[IDX_W-1:0]] <= {wr_prefix, wr_byte};
        end
    end

    always_comb begin
        entry      = mem[rd_off[IDX_W-1:0]];
        rd_literal = (rd_addr < CODE_W'(LIT));
        if (rd_literal) begin
            rd_prefix = '0;
            rd_byte   = rd_addr[BYTE_W-1:0];
        end else begin
            rd_prefix = entry[ENT_W-1:BYTE_W];
            rd_byte   = entry[BYTE_W-1:0];
        end
    end

    // R3
    dyn_write_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr >= CODE_W'(LIT)));

endmodule

// File: rtl/lzw_lifo.sv
module lzw_lifo #(
    parameter int DEPTH = 3842,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               top_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] sp_q;
    logic [CNT_W-1:0] top_sp;

    assign count    = sp_q;
    assign top_sp   = sp_q - CNT_W'(1);
    assign top_data = mem[top_sp[PTR_W-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (clear) begin
            sp_q <= '0;
        end else if (push && !pop) begin
            sp_q <= sp_q + CNT_W'(1);
        end else if (pop && !push) begin
            sp_q <= sp_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear) begin
            mem[sp_q[PTR_W-1:0]] <= push_data;
        end
    end

    // R8
    lifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |-> (sp_q < CNT_W'(DEPTH)));

    // R8
    lifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear) |-> (sp_q != '0));

endmodule

// File: rtl/lzw_dec_ctrl.sv
module lzw_dec_ctrl
    import lzw_exp_pkg::*;
#(
    parameter int CODE_W  = 12,
    parameter int BYTE_W  = 8,
    parameter int STACK_D = 3842
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_restart,
    input  logic                         code_valid,
    output logic                         code_ready,
    input  logic [CODE_W-1:0]            code_data,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic                         err_flag,
    output logic [CODE_W-1:0]            rd_addr,
    input  logic [CODE_W-1:0]            rd_prefix,
    input  logic [BYTE_W-1:0]            rd_byte,
    input  logic                         rd_literal,
    output logic                         wr_en,
    output logic [CODE_W-1:0]            wr_addr,
    output logic [CODE_W-1:0]            wr_prefix,
    output logic [BYTE_W-1:0]            wr_byte,
    output logic                         stk_clear,
    output logic                         stk_push,
    output logic [BYTE_W-1:0]            stk_push_data,
    output logic                         stk_pop,
    input  logic [$clog2(STACK_D+1)-1:0] stk_count
);

    localparam int DEPTH = 1 << CODE_W;
    localparam int LIT   = 1 << BYTE_W;
    localparam int NF_W  = CODE_W + 1;
    localparam int CNT_W = $clog2(STACK_D + 1);

    lzw_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] walk_q;
    logic [CODE_W-1:0] prev_code_q;
    logic [BYTE_W-1:0] first_q;
    logic [BYTE_W-1:0] prev_first_q;
    logic              have_prev_q;
    logic [NF_W-1:0]   next_free_q;
    logic              err_q;

    logic [NF_W-1:0]   code_ext;
    logic              code_is_next;
    logic              code_bad;
    logic              accept;
    logic              take_ok;
    logic              dict_full;

    assign code_ext     = {1'b0, code_data};
    assign code_is_next = (code_ext == next_free_q);
    assign code_bad     = (code_ext > next_free_q) || (code_is_next && !have_prev_q);
    assign accept       = (state_q == ST_IDLE) && code_valid && !frame_restart;
    assign take_ok      = accept && !code_bad;
    assign dict_full    = (next_free_q == NF_W'(DEPTH));
    assign err_flag     = err_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (frame_restart) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (take_ok)    state_d = ST_WALK;
                ST_WALK: if (rd_literal) state_d = ST_LINK;
                ST_LINK:                 state_d = ST_EMIT;
                ST_EMIT: if (out_ready && (stk_count == CNT_W'(1))) state_d = ST_IDLE;
                default:                 state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        code_ready    = (state_q == ST_IDLE) && !frame_restart;
        out_valid     = (state_q == ST_EMIT) && !frame_restart;
        stk_clear     = frame_restart;
        stk_push      = 1'b0;
        stk_push_data = rd_byte;
        stk_pop       = 1'b0;
        rd_addr       = walk_q;
        wr_en         = 1'b0;
        wr_addr       = next_free_q[CODE_W-1:0];
        wr_prefix     = prev_code_q;
        wr_byte       = first_q;
        unique case (state_q)
            ST_IDLE: begin
                // Undefined-code case: the repeated first byte goes to the bottom
                if (take_ok && code_is_next) begin
                    stk_push      = 1'b1;
                    stk_push_data = prev_first_q;
                end
            end
            ST_WALK: stk_push = !frame_restart;
            ST_LINK: wr_en    = have_prev_q && !dict_full && !frame_restart;
            ST_EMIT: stk_pop  = out_valid && out_ready;
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q       <= '0;
            walk_q       <= '0;
            prev_code_q  <= '0;
            first_q      <= '0;
            prev_first_q <= '0;
            have_prev_q  <= 1'b0;
            next_free_q  <= NF_W'(LIT);
            err_q        <= 1'b0;
        end else if (frame_restart) begin
            have_prev_q  <= 1'b0;
            next_free_q  <= NF_W'(LIT);
            err_q        <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && code_bad) begin
                        err_q <= 1'b1;
                    end else if (take_ok) begin
                        code_q <= code_data;
                        walk_q <= code_is_next ? prev_code_q : code_data;
                    end
                end
                ST_WALK: begin
                    if (rd_literal) first_q <= rd_byte;
                    else            walk_q  <= rd_prefix;
                end
                ST_LINK: begin
                    if (wr_en) next_free_q <= next_free_q + NF_W'(1);
                    prev_code_q  <= code_q;
                    prev_first_q <= first_q;
                    have_prev_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !frame_restart) |=> err_q);

    // R6
    next_free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_free_q <= NF_W'(DEPTH));

    // R3
    table_grows_only_in_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_restart && (state_q != ST_LINK)) |=> $stable(next_free_q));

    // R7
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_restart |=> ((next_free_q == NF_W'(LIT)) && !err_q && !have_prev_q));

endmodule

// File: rtl/lzw_expander.sv
module lzw_expander #(
    parameter int CODE_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_restart,
    input  logic              code_valid,
    output logic              code_ready,
    input  logic [CODE_W-1:0] code_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              err_flag
);

    // Longest string: entry 4095 can hold 3841 bytes; one spare slot.
    localparam int STACK_D = (1 << CODE_W) - (1 << BYTE_W) + 2;
    localparam int CNT_W   = $clog2(STACK_D + 1);

    logic [CODE_W-1:0] rd_addr, rd_prefix, wr_addr, wr_prefix;
    logic [BYTE_W-1:0] rd_byte, wr_byte, stk_push_data;
    logic              rd_literal, wr_en;
    logic              stk_clear, stk_push, stk_pop;
    logic [CNT_W-1:0]  stk_count;

    lzw_dec_ctrl #(
        .CODE_W (CODE_W),
        .BYTE_W (BYTE_W),
        .STACK_D(STACK_D)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_restart(frame_restart),
        .code_valid   (code_valid),
        .code_ready   (code_ready),
        .code_data    (code_data),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .err_flag     (err_flag),
        .rd_addr      (rd_addr),
        .rd_prefix    (rd_prefix),
        .rd_byte      (rd_byte),
        .rd_literal   (rd_literal),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_prefix    (wr_prefix),
        .wr_byte      (wr_byte),
        .stk_clear    (stk_clear),
        .stk_push     (stk_push),
        .stk_push_data(stk_push_data),
        .stk_pop      (stk_pop),
        .stk_count    (stk_count)
    );

    lzw_dict_mem #(
        .CODE_W(CODE_W),
        .BYTE_W(BYTE_W)
    ) u_dict (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_prefix (wr_prefix),
        .wr_byte   (wr_byte),
        .rd_addr   (rd_addr),
        .rd_prefix (rd_prefix),
        .rd_byte   (rd_byte),
        .rd_literal(rd_literal)
    );

    lzw_lifo #(
        .DEPTH(STACK_D),
        .W    (BYTE_W)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (stk_clear),
        .push     (stk_push),
        .push_data(stk_push_data),
        .pop      (stk_pop),
        .top_data (out_data),
        .count    (stk_count)
    );

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (frame_restart || (out_valid && $stable(out_data))));

    // R8
    no_take_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code_ready && !err_flag && (code_data > 12'd4095 - 12'd4095)) |=> !out_valid);

endmodule

// File: tb/test_lzw_expander.sv
module test_lzw_expander;

    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 12;
    localparam int BYTE_W     = 8;
    localparam int DEPTH      = 4096;

    logic              clk, rst_n, frame_restart;
    logic              code_valid, code_ready;
    logic [CODE_W-1:0] code_data;
    logic              out_valid, out_ready;
    logic [BYTE_W-1:0] out_data;
    logic              err_flag;

    lzw_expander #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) i_lzw_expander (
        .clk(clk), .rst_n(rst_n), .frame_restart(frame_restart),
        .code_valid(code_valid), .code_ready(code_ready), .code_data(code_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .err_flag(err_flag)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    int  sink_mode = 0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_ph;      // 0 idle, 1 busy, 2 emitting
    int         m_busy;
    int         m_next;
    int         m_prev;
    bit         m_have;
    bit         m_err;
    string      m_tag = "R3";
    logic [7:0] m_q[$];
    logic [7:0] m_tmp[$];
    int         m_pre [DEPTH];
    logic [7:0] m_byt [DEPTH];

    task automatic build_str(input int c);
        int k = c;
        m_tmp.delete();
        while (k >= 256) begin
            m_tmp.push_front(m_byt[k]);
            k = m_pre[k];
        end
        m_tmp.push_front(8'(k));
    endtask

    task automatic model_reset();
        m_ph = 0; m_busy = 0; m_next = 256; m_prev = 0; m_have = 0; m_err = 0;
        m_q.delete();
    endtask

    task automatic model_accept(input int c);
        int w;
        if (c > m_next || (c == m_next && !m_have)) begin
            m_err = 1;
            return;
        end
        if (c == m_next) begin
            build_str(m_prev);
            m_tmp.push_back(m_tmp[0]);
            w = m_tmp.size() - 1;
            m_tag = "R4";
        end else begin
            build_str(c);
            w = m_tmp.size();
            m_tag = (m_tmp.size() == 1) ? "R2" : "R3";
        end
        if (m_next == DEPTH) m_tag = "R6";
        if (m_have && m_next < DEPTH) begin
            m_pre[m_next] = m_prev;
            m_byt[m_next] = m_tmp[0];
            m_next++;
        end
        m_prev = c;
        m_have = 1;
        m_q    = m_tmp;
        m_busy = w + 1;
        m_ph   = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else if (frame_restart) begin
            m_ph = 0; m_busy = 0; m_next = 256; m_have = 0; m_err = 0;
            m_q.delete();
        end else begin
            case (m_ph)
                0: if (code_valid) model_accept(int'(code_data));
                1: begin
                    m_busy--;
                    if (m_busy == 0) m_ph = 2;
                end
                default: if (out_ready) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) m_ph = 0;
                end
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(32'(code_ready), 32'(m_ph == 0 && !frame_restart), "R8", "code_ready");
            check(32'(out_valid), 32'(m_ph == 2 && !frame_restart), "R8", "out_valid");
            if (m_ph == 2 && !frame_restart && out_valid)
                check(32'(out_data), 32'(m_q[0]), m_tag, "out_data");
            check(32'(err_flag), 32'(m_err), "R5", "err_flag");
        end
    end

    // ---------------- sink ----------------
    logic [31:0] sink_lf = 32'h1234_5678;
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            sink_lf   = sink_lf * 32'd1103515245 + 32'd12345;
            out_ready = (sink_mode == 0) ? 1'b1 : (sink_lf[20:19] != 2'b00);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_code(input int c);
        bit got;
        code_data  = CODE_W'(c);
        code_valid = 1'b1;
        do begin
            @(negedge clk);
            got = code_ready;
            @(posedge clk);
            #1;
        end while (!got);
        code_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_ph != 0);
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_restart();
        frame_restart = 1'b1;
        @(posedge clk);
        #1;
        frame_restart = 1'b0;
    endtask

    logic [31:0] gen_lf = 32'hCAFE_0001;

    initial begin
        rst_n = 1'b0; frame_restart = 1'b0; code_valid = 1'b0; code_data = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(32'(code_ready), 1, "R1", "reset code_ready");
        check(32'(out_valid), 0, "R1", "reset out_valid");
        check(32'(err_flag), 0, "R1", "reset err_flag");
        @(posedge clk);
        #1;

        // Short frame with a not-yet-defined code (R2, R3, R4)
        send_code(65); send_code(66); send_code(256);
        send_code(258); send_code(257); send_code(259);
        wait_idle();

        // Generated frame under a stalling sink (R3, R4, R8)
        sink_mode = 1;
        pulse_restart();
        for (int i = 0; i < 150; i++) begin
            int c;
            gen_lf = gen_lf * 32'd1103515245 + 32'd12345;
            if (!m_have) c = int'(gen_lf[23:16]);
            else case (gen_lf[9:8])
                2'd0:    c = int'(gen_lf[23:16]);
                2'd1:    c = m_next;
                default: c = (m_next - 1 - int'(gen_lf[14:12] % 3'd6) < 0) ? 0
                            : m_next - 1 - int'(gen_lf[14:12] % 3'd6);
            endcase
            send_code(c);
        end
        wait_idle();

        // Restart in the middle of a string (R7)
        send_code(m_next - 1);
        repeat (3) @(posedge clk);
        #1;
        pulse_restart();
        @(negedge clk);
        check(32'(out_valid), 0, "R7", "out_valid after restart");
        check(32'(code_ready), 1, "R7", "code_ready after restart");
        @(posedge clk);
        #1;
        sink_mode = 0;

        // Undefined code (R5)
        send_code(72); send_code(73);
        send_code(m_next + 5);
        @(negedge clk);
        check(32'(err_flag), 1, "R5", "err after bad code");
        check(32'(out_valid), 0, "R5", "no output for bad code");
        @(posedge clk);
        #1;
        send_code(257);
        wait_idle();
        check(32'(err_flag), 1, "R5", "err stays set");
        pulse_restart();
        @(negedge clk);
        check(32'(err_flag), 0, "R7", "err cleared by restart");
        @(posedge clk);
        #1;
        send_code(256);
        @(negedge clk);
        check(32'(err_flag), 1, "R5", "first code 256 rejected");
        @(posedge clk);
        #1;
        pulse_restart();

        // Fill the table and keep decoding (R6)
        send_code(1);
        for (int i = 0; i < 3845; i++) send_code(i % 256);
        wait_idle();
        check(32'(m_next), 32'(DEPTH), "R6", "model table full");
        send_code(4095); send_code(4000); send_code(300); send_code(4095);
        wait_idle();
        check(32'(err_flag), 0, "R6", "no error after freeze");

        repeat (4) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule